// File: doc/BRIEF.md
# Indirect Control Register Interface

This block is the host-facing register front end of a network controller. The host reaches every control/status register (CSR) and bus configuration register (BCR) through three byte offsets: a register pointer that selects an index, a CSR data port and a BCR data port. A write or read at a data port acts on whichever register the pointer currently selects. The host drives one access per cycle with a write strobe; read data is combinational from the offset and the current register state.

Behind the ports sit the main control word (start, stop and init commands, event flags that are cleared by writing a one, interrupt enable, receive-on and transmit-on), an interrupt mask register, a mode register, a ring-length register and a read-only window onto a PHY's management registers. The receive and transmit engines take their enables, ring lengths and a ring-position clear pulse from this block. Fetching the initialization block from memory happens elsewhere; its completion arrives as a one-cycle `init_done` pulse.

Top module: `nic_reg_frontend`

## Requirements
- R1: After reset the control word (CSR 0) reads 0x0004 (stopped). The pointer, the mode and mask registers and both ring log2 fields read 0. `irq`, `rx_on`, `tx_on` and `ring_pos_clr` are low, and both ring lengths are 1.
- R2: Offset 0x14 holds the 8-bit register pointer, written from data bits 7:0 and read back zero-extended. Offset 0x10 is the CSR data port and 0x1C the BCR data port. Any other offset reads 0 and ignores writes.
- R3: A CSR 0 write with bit 2 (stop) set makes CSR 0 exactly 0x0004 on the next cycle. Any init (bit 0) or start (bit 1) in that write, and an `init_done` pulse in the same cycle, are ignored. `ring_pos_clr` is high for exactly the one cycle after each such write.
- R4: Bits 14:8 of CSR 0 are event flags, with bit 8 the init-done flag. Writing a one to a flag clears it. An `init_done` pulse sets bit 8, and this takes priority over a clear of bit 8 written in the same cycle.
- R5: On every CSR 0 write without stop, interrupt enable (bit 6) takes the written value of bit 6.
- R6: A CSR 0 write with bit 0 set sets init and clears stop. A write with bit 1 set sets start and clears stop. Both bits then hold until a stop write.
- R7: `rx_on` (CSR 0 bit 5) equals start AND NOT mode bit 0 (receive disable, CSR 15). `tx_on` (CSR 0 bit 4) equals start AND NOT mode bit 1 (transmit disable). Both take the new value in the cycle after a start write or a mode write.
- R8: CSR 0 bit 7 (interrupt flag) is set whenever an event flag in bits 14:8 of CSR 0 is also set in bits 14:8 of the mask register (CSR 3). The flag is evaluated from the values both registers take in the same cycle.
- R9: `irq` is a level that is high exactly while CSR 0 bits 7 and 6 are both set.
- R10: A write to CSR 6 loads the receive ring log2 from bits 11:8 and the transmit ring log2 from bits 15:12. A read returns only those two fields. Each ring length output is 2^n, limited to 512.
- R11: A read of BCR 34 returns the PHY register addressed by BCR 33, with the PHY number in bits 9:5 and the register number in bits 4:0. PHY 0 answers register 0 with 0x1000, 1 with 0x782D, 2 with 0x2000, 3 with 0x5C01 and 4 with 0x01E1. Its registers 22 to 25 return 0x0001, 0x8060, 0x8020 and 0x0820, register 27 returns 0x3800 and register 28 returns 0xA3B9. Every other PHY number or register returns 0. Writes to BCR 34 are ignored. BCR 9 always reads 1.
- R12: Every other CSR index below 32 and every other BCR index below 64 is plain storage of the low 16 written bits. Indices at or above these depths read 0.
- R13: Bits 15 and 3 of CSR 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current offset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset and pointer |
| init_done | input | 1 | One-cycle pulse: initialization block fetch finished |
| irq | output | 1 | Interrupt request level |
| rx_on | output | 1 | Receive engine enable |
| tx_on | output | 1 | Transmit engine enable |
| ring_pos_clr | output | 1 | One-cycle pulse that resets both ring positions |
| rx_ring_len | output | 10 | Effective receive ring length |
| tx_ring_len | output | 10 | Effective transmit ring length |

## Verification
The bound checker watches the invariants on every cycle: the result of a stop write, the single position-clear pulse, the init-done flag being set by its pulse, start holding until a stop, the enable and interrupt-flag rules against the live mode and mask values, `irq` requiring enable, one-hot ring lengths and the reserved bits. Only the bench scenarios can show the exact register images after mixed command words, the set-over-clear race on the init-done flag, the ring-length cap, the PHY read values and the rejected writes to the fixed BCRs. A behavioural model in the bench keeps the read data and every output aligned with these scenarios cycle by cycle.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;

    typedef logic [15:0] reg16_t;
    typedef logic [3:0]  log2_t;

    // byte offsets of the three host ports
    localparam logic [7:0] OFS_CSR_DATA = 8'h10;
    localparam logic [7:0] OFS_PTR      = 8'h14;
    localparam logic [7:0] OFS_BCR_DATA = 8'h1C;

    // register indices with special behaviour
    localparam logic [7:0] IDX_CTRL     = 8'd0;
    localparam logic [7:0] IDX_MASK     = 8'd3;
    localparam logic [7:0] IDX_RING     = 8'd6;
    localparam logic [7:0] IDX_MODE     = 8'd15;
    localparam logic [7:0] IDX_FIXED    = 8'd9;
    localparam logic [7:0] IDX_MII_SEL  = 8'd33;
    localparam logic [7:0] IDX_MII_DATA = 8'd34;

    // control word bit positions
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_IENA = 6;
    localparam int B_INTR = 7;
    localparam int EVT_LO = 8;
    localparam int EVT_HI = 14;
    localparam int EVT_W  = EVT_HI - EVT_LO + 1;

    // mode register disable bits
    localparam int M_RXDIS = 0;
    localparam int M_TXDIS = 1;

    localparam reg16_t CTRL_STOPPED = 16'h0004;

endpackage

// File: rtl/nic_ctrl_next.sv
module nic_ctrl_next
    import nic_reg_pkg::*;
(
    input  reg16_t           ctrl_q,
    input  logic             ctrl_wr,
    input  reg16_t           wdata,
    input  logic             init_done,
    input  logic [1:0]       mode_dis,
    input  logic [EVT_W-1:0] evt_mask,
    output reg16_t           ctrl_d,
    output logic             stop_cmd
);

    always_comb begin
        stop_cmd = ctrl_wr & wdata[B_STOP];
        ctrl_d   = ctrl_q;
        if (stop_cmd) begin
            // stop wins over everything else arriving this cycle
            ctrl_d = CTRL_STOPPED;
        end else begin
            if (ctrl_wr) begin
                ctrl_d[EVT_HI:EVT_LO] = ctrl_q[EVT_HI:EVT_LO] & ~wdata[EVT_HI:EVT_LO];
                ctrl_d[B_IENA]        = wdata[B_IENA];
                if (wdata[B_INIT]) begin
                    ctrl_d[B_INIT] = 1'b1;
                    ctrl_d[B_STOP] = 1'b0;
                end
                if (wdata[B_STRT]) begin
                    ctrl_d[B_STRT] = 1'b1;
                    ctrl_d[B_STOP] = 1'b0;
                end
            end
            // set after clear so a coincident pulse is never lost
            if (init_done) begin
                ctrl_d[EVT_LO] = 1'b1;
            end
            ctrl_d[B_RXON] = ctrl_d[B_STRT] & ~mode_dis[M_RXDIS];
            ctrl_d[B_TXON] = ctrl_d[B_STRT] & ~mode_dis[M_TXDIS];
            ctrl_d[B_INTR] = |(ctrl_d[EVT_HI:EVT_LO] & evt_mask);
        end
        ctrl_d[15] = 1'b0;
        ctrl_d[3]  = 1'b0;
    end

endmodule

// File: rtl/nic_ring_len.sv
module nic_ring_len #(
    parameter int MAX_LOG2 = 9
) (
    input  logic [3:0]        log2_n,
    output logic [MAX_LOG2:0] len
);

    localparam int LEN_W = MAX_LOG2 + 1;

    always_comb begin
        if (int'(log2_n) >= MAX_LOG2) begin
            len = LEN_W'(1) << MAX_LOG2;
        end else begin
            len = LEN_W'(1) << log2_n;
        end
    end

endmodule

// File: rtl/nic_mii_rom.sv
module nic_mii_rom
    import nic_reg_pkg::*;
#(
    parameter int PHY_ADDR = 0
) (
    input  logic [4:0] phy_sel,
    input  logic [4:0] reg_sel,
    output reg16_t     data
);

    always_comb begin
        data = '0;
        if (phy_sel == 5'(PHY_ADDR)) begin
            case (reg_sel)
                5'd0:    data = 16'h1000;
                5'd1:    data = 16'h782D;
                5'd2:    data = 16'h2000;
                5'd3:    data = 16'h5C01;
                5'd4:    data = 16'h01E1;
                5'd22:   data = 16'h0001;
                5'd23:   data = 16'h8060;
                5'd24:   data = 16'h8020;
                5'd25:   data = 16'h0820;
                5'd27:   data = 16'h3800;
                5'd28:   data = 16'hA3B9;
                default: data = '0;
            endcase
        end
    end

endmodule

// File: rtl/nic_reg_frontend.sv
module nic_reg_frontend
    import nic_reg_pkg::*;
#(
    parameter int CSR_DEPTH     = 32,
    parameter int BCR_DEPTH     = 64,
    parameter int RING_MAX_LOG2 = 9,
    parameter int PHY_ADDR      = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic                    init_done,
    output logic                    irq,
    output logic                    rx_on,
    output logic                    tx_on,
    output logic                    ring_pos_clr,
    output logic [RING_MAX_LOG2:0]  rx_ring_len,
    output logic [RING_MAX_LOG2:0]  tx_ring_len
);

    localparam int         CSR_AW  = $clog2(CSR_DEPTH);
    localparam int         BCR_AW  = $clog2(BCR_DEPTH);
    localparam logic [8:0] CSR_LIM = 9'(CSR_DEPTH);
    localparam logic [8:0] BCR_LIM = 9'(BCR_DEPTH);

    typedef struct packed {
        logic [7:0]                  ptr;
        reg16_t                      ctrl;
        log2_t                       rx_log;
        log2_t                       tx_log;
        logic                        pos_clr;
        logic [CSR_DEPTH-1:0][15:0]  csr_mem;
        logic [BCR_DEPTH-1:0][15:0]  bcr_mem;
    } state_t;

    state_t state_q, state_d;

    logic             csr_in, bcr_in;
    logic             wr_ptr, wr_ctrl, wr_ring, wr_csr, wr_bcr;
    logic [1:0]       mode_dis_q, mode_nxt;
    logic [EVT_W-1:0] mask_q, mask_nxt;
    reg16_t           ctrl_nxt, mii_data;
    logic             stop_cmd;
    logic [CSR_AW-1:0] cidx;
    logic [BCR_AW-1:0] bidx;
    wire              unused_hi = &{1'b0, bus_wdata[31:16]};

    assign csr_in     = {1'b0, state_q.ptr} < CSR_LIM;
    assign bcr_in     = {1'b0, state_q.ptr} < BCR_LIM;
    assign cidx       = state_q.ptr[CSR_AW-1:0];
    assign bidx       = state_q.ptr[BCR_AW-1:0];
    assign mode_dis_q = state_q.csr_mem[IDX_MODE][1:0];
    assign mask_q     = state_q.csr_mem[IDX_MASK][EVT_HI:EVT_LO];

    // port and index decode
    always_comb begin
        wr_ptr  = bus_wr && (bus_addr == OFS_PTR);
        wr_ctrl = bus_wr && (bus_addr == OFS_CSR_DATA) && (state_q.ptr == IDX_CTRL);
        wr_ring = bus_wr && (bus_addr == OFS_CSR_DATA) && (state_q.ptr == IDX_RING);
        wr_csr  = bus_wr && (bus_addr == OFS_CSR_DATA) && !wr_ctrl && !wr_ring && csr_in;
        wr_bcr  = bus_wr && (bus_addr == OFS_BCR_DATA) && bcr_in
                  && (state_q.ptr != IDX_FIXED) && (state_q.ptr != IDX_MII_DATA);
        mode_nxt = (wr_csr && state_q.ptr == IDX_MODE) ? bus_wdata[1:0] : mode_dis_q;
        mask_nxt = (wr_csr && state_q.ptr == IDX_MASK) ? bus_wdata[EVT_HI:EVT_LO] : mask_q;
    end

    nic_ctrl_next u_ctrl (
        .ctrl_q    (state_q.ctrl),
        .ctrl_wr   (wr_ctrl),
        .wdata     (bus_wdata[15:0]),
        .init_done (init_done),
        .mode_dis  (mode_nxt),
        .evt_mask  (mask_nxt),
        .ctrl_d    (ctrl_nxt),
        .stop_cmd  (stop_cmd)
    );

    nic_mii_rom #(.PHY_ADDR(PHY_ADDR)) u_mii (
        .phy_sel (state_q.bcr_mem[IDX_MII_SEL][9:5]),
        .reg_sel (state_q.bcr_mem[IDX_MII_SEL][4:0]),
        .data    (mii_data)
    );

    // next state
    always_comb begin
        state_d         = state_q;
        state_d.ctrl    = ctrl_nxt;
        state_d.pos_clr = stop_cmd;
        if (wr_ptr) begin
            state_d.ptr = bus_wdata[7:0];
        end
        if (wr_ring) begin
            state_d.rx_log = bus_wdata[11:8];
            state_d.tx_log = bus_wdata[15:12];
        end
        if (wr_csr) begin
            state_d.csr_mem[cidx] = bus_wdata[15:0];
        end
        if (wr_bcr) begin
            state_d.bcr_mem[bidx] = bus_wdata[15:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.ctrl <= CTRL_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PTR: bus_rdata[7:0] = state_q.ptr;
            OFS_CSR_DATA: begin
                if (state_q.ptr == IDX_CTRL) begin
                    bus_rdata[15:0] = state_q.ctrl;
                end else if (state_q.ptr == IDX_RING) begin
                    bus_rdata[15:8] = {state_q.tx_log, state_q.rx_log};
                end else if (csr_in) begin
                    bus_rdata[15:0] = state_q.csr_mem[cidx];
                end
            end
            OFS_BCR_DATA: begin
                if (state_q.ptr == IDX_FIXED) begin
                    bus_rdata = 32'd1;
                end else if (state_q.ptr == IDX_MII_DATA) begin
                    bus_rdata[15:0] = mii_data;
                end else if (bcr_in) begin
                    bus_rdata[15:0] = state_q.bcr_mem[bidx];
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    // ring length decode, one per direction
    logic [1:0][3:0]             ring_log;
    logic [1:0][RING_MAX_LOG2:0] ring_len;
    assign ring_log[0] = state_q.rx_log;
    assign ring_log[1] = state_q.tx_log;

    for (genvar g = 0; g < 2; g++) begin : g_ring
        nic_ring_len #(.MAX_LOG2(RING_MAX_LOG2)) u_len (
            .log2_n (ring_log[g]),
            .len    (ring_len[g])
        );
    end

    assign rx_ring_len  = ring_len[0];
    assign tx_ring_len  = ring_len[1];
    assign irq          = state_q.ctrl[B_INTR] & state_q.ctrl[B_IENA];
    assign rx_on        = state_q.ctrl[B_RXON];
    assign tx_on        = state_q.ctrl[B_TXON];
    assign ring_pos_clr = state_q.pos_clr;

endmodule

// File: rtl/nic_reg_frontend_chk.sv
module nic_reg_frontend_chk #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             init_done,
    input logic             irq,
    input logic             rx_on,
    input logic             tx_on,
    input logic             ring_pos_clr,
    input logic [LEN_W-1:0] rx_ring_len,
    input logic [LEN_W-1:0] tx_ring_len,
    input logic [7:0]       rap,
    input logic [15:0]      ctrl,
    input logic [1:0]       mode_dis,
    input logic [6:0]       mask
);

    logic stop_w;
    assign stop_w = bus_wr && (bus_addr == 8'h10) && (rap == 8'd0) && bus_wdata[2];

    a_r3_stop_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (ctrl == 16'h0004) && ring_pos_clr && !irq && !rx_on && !tx_on);

    a_r3_clear_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ring_pos_clr |-> (ctrl == 16'h0004));

    a_r4_init_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !stop_w) |=> ctrl[8]);

    a_r6_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1] && !stop_w) |=> ctrl[1]);

    a_r7_rx_rule: assert property (@(posedge clk) disable iff (!rst_n)
        rx_on == (ctrl[1] && !mode_dis[0]));

    a_r7_tx_rule: assert property (@(posedge clk) disable iff (!rst_n)
        tx_on == (ctrl[1] && !mode_dis[1]));

    a_r8_flag_rule: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[7] == |(ctrl[14:8] & mask));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl[6] && ctrl[7]));

    a_r10_len_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rx_ring_len) == 1) && ($countones(tx_ring_len) == 1));

    a_r13_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[15] && !ctrl[3]);

endmodule

bind nic_reg_frontend nic_reg_frontend_chk #(.LEN_W(RING_MAX_LOG2 + 1)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .init_done    (init_done),
    .irq          (irq),
    .rx_on        (rx_on),
    .tx_on        (tx_on),
    .ring_pos_clr (ring_pos_clr),
    .rx_ring_len  (rx_ring_len),
    .tx_ring_len  (tx_ring_len),
    .rap          (state_q.ptr),
    .ctrl         (state_q.ctrl),
    .mode_dis     (mode_dis_q),
    .mask         (mask_q)
);

// File: tb/nic_reg_frontend_bench.sv
`timescale 1ns/1ps
module nic_reg_frontend_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic        init_done = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, rx_on, tx_on, ring_pos_clr;
    logic [9:0]  rx_ring_len, tx_ring_len;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nic_reg_frontend u_nic_reg_frontend (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_done(init_done),
        .irq(irq), .rx_on(rx_on), .tx_on(tx_on), .ring_pos_clr(ring_pos_clr),
        .rx_ring_len(rx_ring_len), .tx_ring_len(tx_ring_len)
    );

    // ---------------- behavioural reference model ----------------
    int m_rap, m_ctrl, m_rxl, m_txl, m_clr;
    int m_csr [0:31];
    int m_bcr [0:63];

    function automatic int phy_val(int sel);
        int phy = (sel >> 5) & 31;
        int rg  = sel & 31;
        if (phy != 0) return 0;
        case (rg)
            0: return 'h1000;   1: return 'h782D;   2: return 'h2000;
            3: return 'h5C01;   4: return 'h01E1;  22: return 'h0001;
            23: return 'h8060; 24: return 'h8020;  25: return 'h0820;
            27: return 'h3800; 28: return 'hA3B9;
            default: return 0;
        endcase
    endfunction

    function automatic int ring_of(int n);
        return (n >= 9) ? 512 : (1 << n);
    endfunction

    function automatic int m_read(int a);
        if (a == 'h14) return m_rap;
        if (a == 'h10) begin
            if (m_rap == 0) return m_ctrl;
            if (m_rap == 6) return (m_txl << 12) | (m_rxl << 8);
            if (m_rap < 32) return m_csr[m_rap];
            return 0;
        end
        if (a == 'h1C) begin
            if (m_rap == 9) return 1;
            if (m_rap == 34) return phy_val(m_bcr[33]);
            if (m_rap < 64) return m_bcr[m_rap];
            return 0;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        int wd;
        bit cw;
        wd = bus_wdata;
        cw = 0;
        if (!rst_n) begin
            m_rap = 0; m_ctrl = 4; m_rxl = 0; m_txl = 0; m_clr = 0;
            for (int i = 0; i < 32; i++) m_csr[i] = 0;
            for (int i = 0; i < 64; i++) m_bcr[i] = 0;
        end else begin
            if (bus_wr) begin
                if (bus_addr == 8'h14) m_rap = wd & 'hFF;
                else if (bus_addr == 8'h10) begin
                    if (m_rap == 0) cw = 1;
                    else if (m_rap == 6) begin
                        m_rxl = (wd >> 8) & 15;
                        m_txl = (wd >> 12) & 15;
                    end else if (m_rap < 32) m_csr[m_rap] = wd & 'hFFFF;
                end else if (bus_addr == 8'h1C) begin
                    if (m_rap != 9 && m_rap != 34 && m_rap < 64) m_bcr[m_rap] = wd & 'hFFFF;
                end
            end
            if (cw && wd[2]) begin
                m_ctrl = 4;
                m_clr = 1;
            end else begin
                m_clr = 0;
                if (cw) begin
                    m_ctrl = m_ctrl & ~(wd & 'h7F00);
                    m_ctrl = (m_ctrl & ~'h40) | (wd & 'h40);
                    if (wd[0]) m_ctrl = (m_ctrl | 1) & ~4;
                    if (wd[1]) m_ctrl = (m_ctrl | 2) & ~4;
                end
                if (init_done) m_ctrl = m_ctrl | 'h100;
                m_ctrl = m_ctrl & ~'hB0;
                if ((m_ctrl & 2) != 0 && (m_csr[15] & 1) == 0) m_ctrl = m_ctrl | 'h20;
                if ((m_ctrl & 2) != 0 && (m_csr[15] & 2) == 0) m_ctrl = m_ctrl | 'h10;
                if ((m_ctrl & m_csr[3] & 'h7F00) != 0) m_ctrl = m_ctrl | 'h80;
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(bus_rdata, m_read(bus_addr), "R2 read data vs model");
            chk(irq, ((m_ctrl & 'hC0) == 'hC0) ? 1 : 0, "R9 irq vs model");
            chk(rx_on, (m_ctrl >> 5) & 1, "R7 rx_on vs model");
            chk(tx_on, (m_ctrl >> 4) & 1, "R7 tx_on vs model");
            chk(ring_pos_clr, m_clr, "R3 ring_pos_clr vs model");
            chk(rx_ring_len, ring_of(m_rxl), "R10 rx length vs model");
            chk(tx_ring_len, ring_of(m_txl), "R10 tx length vs model");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic csr_wr(input int idx, input logic [31:0] d);
        wr(8'h14, 32'(idx));
        wr(8'h10, d);
    endtask

    task automatic csr_rd(input int idx, input int exp, input string tag);
        wr(8'h14, 32'(idx));
        rd(8'h10, exp, tag);
    endtask

    task automatic bcr_wr(input int idx, input logic [31:0] d);
        wr(8'h14, 32'(idx));
        wr(8'h1C, d);
    endtask

    task automatic bcr_rd(input int idx, input int exp, input string tag);
        wr(8'h14, 32'(idx));
        rd(8'h1C, exp, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, 'h0004, "R1 control word after reset");
        rd(8'h14, 0, "R1 pointer after reset");
        chk(irq, 0, "R1 irq after reset");
        chk(rx_ring_len, 1, "R1 rx length after reset");
        chk(tx_ring_len, 1, "R1 tx length after reset");

        // R2 pointer port and unused offsets
        wr(8'h14, 32'h0000_01A5);
        rd(8'h14, 'hA5, "R2 pointer readback");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 0, "R2 unused offset");

        // R12 plain storage and depth limits
        csr_wr(20, 32'h1234_BEEF);
        csr_rd(20, 'hBEEF, "R12 csr storage");
        csr_wr(40, 32'h5555);
        csr_rd(40, 0, "R12 csr beyond depth");
        bcr_wr(50, 32'hCAFE);
        bcr_rd(50, 'hCAFE, "R12 bcr storage");
        bcr_wr(70, 32'h7777);
        bcr_rd(70, 0, "R12 bcr beyond depth");

        // R10 ring lengths
        csr_wr(6, 32'hA3FF);
        csr_rd(6, 'hA300, "R10 ring register readback");
        chk(rx_ring_len, 8, "R10 rx length 2^3");
        chk(tx_ring_len, 512, "R10 tx length capped");
        csr_wr(6, 32'h8900);
        chk(rx_ring_len, 512, "R10 rx length 2^9");
        chk(tx_ring_len, 256, "R10 tx length 2^8");

        // R6 R7 init and start with mode disables
        csr_wr(15, 32'h0001);
        csr_wr(0, 32'h0003);
        csr_rd(0, 'h0013, "R6 init and start clear stop");
        chk(rx_on, 0, "R7 receive disabled by mode");
        chk(tx_on, 1, "R7 transmit on");
        csr_wr(15, 32'h0002);
        chk(rx_on, 1, "R7 mode write recomputes rx_on");
        chk(tx_on, 0, "R7 mode write recomputes tx_on");
        csr_rd(0, 'h0023, "R7 control word after mode change");

        // R4 R8 R9 events, mask, enable
        @(negedge clk); init_done = 1'b1;
        @(negedge clk); init_done = 1'b0;
        rd(8'h10, 'h0123, "R4 init_done sets flag, mask 0 keeps flag low");
        csr_wr(3, 32'h0100);
        csr_rd(0, 'h01A3, "R8 mask raises interrupt flag");
        chk(irq, 0, "R9 no irq without enable");
        wr(8'h10, 32'h0040);
        rd(8'h10, 'h01E3, "R5 enable stored");
        chk(irq, 1, "R9 irq with flag and enable");
        wr(8'h10, 32'h0140);
        rd(8'h10, 'h0063, "R4 write one clears flag");
        chk(irq, 0, "R9 irq drops with flag");
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0140; init_done = 1'b1;
        @(negedge clk); bus_wr = 1'b0; init_done = 1'b0;
        rd(8'h10, 'h01E3, "R4 set wins over clear");
        wr(8'h10, 32'h8048);
        rd(8'h10, 'h01E3, "R13 reserved bits stay zero");
        wr(8'h10, 32'h0000);
        rd(8'h10, 'h01A3, "R5 enable cleared by write");
        chk(irq, 0, "R9 irq off when disabled");

        // R3 stop dominates
        wr(8'h10, 32'h0047);
        chk(ring_pos_clr, 1, "R3 position clear pulse");
        rd(8'h10, 'h0004, "R3 stop wipes control word");
        chk(ring_pos_clr, 0, "R3 position clear single cycle");
        chk(rx_on, 0, "R3 rx off after stop");
        chk(tx_on, 0, "R3 tx off after stop");

        // R11 PHY window and fixed BCRs
        bcr_wr(33, 32'h0001);
        bcr_rd(34, 'h782D, "R11 phy0 reg1");
        bcr_wr(33, 32'h0003);
        bcr_rd(34, 'h5C01, "R11 phy0 reg3");
        bcr_wr(33, 32'h0021);
        bcr_rd(34, 0, "R11 other phy reads zero");
        bcr_wr(33, 32'h0002);
        bcr_wr(34, 32'hFFFF);
        bcr_rd(34, 'h2000, "R11 write to data window ignored");
        bcr_rd(9, 1, "R11 fixed register");
        bcr_wr(9, 32'h0077);
        bcr_rd(9, 1, "R11 fixed register ignores write");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule